// File: doc/BRIEF.md
# Built-in self-test sequencer

This block runs a short health check of a signal-processing datapath. A one-cycle `trigger` pulse starts a run of five checks, always in the order 0, 1, 2, 3, 4. Each check has its own engine, and each returns a pass bit computed at run time through registered arithmetic. No pass bit is written as a constant. Check 0 walks a single one through a shift register. Check 1 drives an impulse through a registered integrator. Check 2 computes a radix-2 butterfly with a complex twiddle multiply. Check 3 runs an up counter and a down counter against each other. Check 4 captures a window of converter samples and checks that their signed spread is wide enough to rule out a stuck input.

The sequencer has the states ST_IDLE, ST_CHK0, ST_CHK1, ST_CHK2, ST_CHK3, ST_CHK4 and ST_DONE.
- From ST_IDLE or ST_DONE, a `trigger` moves it to ST_CHK0 and clears all results.
- In each ST_CHKn state, it issues one start pulse to check n and then waits for that check's done pulse.
- The done pulse of check n advances it to the next check state. After check 4 it moves to ST_DONE, where `result_valid` is high.

The results stay unchanged until the next trigger.

Top module: `bist_sequencer`

## Requirements
- R1: After the asynchronous active-low reset, the sequencer is idle, `result_valid` is 0, `result_flags` is 5'b00000 and `result_detail` is 8'h00.
- R2: A trigger runs checks 0 to 4 in order. Bit n of `result_flags` holds the pass of check n. When samples vary widely, the run ends with `result_valid` = 1, flags 5'b11111 and detail 8'h00.
- R3: Check 1 feeds the sequence 5, 0, 0, 0, 0, 0, 0, one value per cycle and sign-extended to the accumulator width, into a registered accumulator computing y[n] = y[n-1] + x[n]. It passes only if the accumulator equals 5 at the end. On failure it clears flag bit 1 and has failure code 8'hC1.
- R4: Check 2 loads A = 8 and B = 4 (both real) and twiddle W = 2+3j. It forms W·B = (8, 12), then A + W·B = (16, 12) and A − W·B = (0, −12) over separate registered states. It passes only when both results match. Its failure code is 8'hF2.
- R5: Check 4 captures 256 samples (`sample_in` is read as signed two's complement when `sample_valid` = 1) and tracks their minimum and maximum. It passes only if max − min > 10. Its failure code is 8'hAD. When only this check fails, the flags read 5'b01111.
- R6: A spread of exactly 10 fails check 4 (flags 5'b01111, detail 8'hAD). A spread of 11 passes.
- R7: `result_detail` holds the failure code of the lowest-numbered failing check: 8'hE0 for check 0, 8'hC1, 8'hF2, 8'hE3 for check 3, or 8'hAD. It is 8'h00 when every check passes.
- R8: An accepted trigger clears flags, detail and `result_valid` in the cycle after it is seen. While a run is in progress, `result_valid` stays 0. After the run ends, the results stay stable until the next trigger.
- R9: A trigger that arrives while a run is in progress is ignored: the run neither restarts nor lengthens.
- R10: A trigger after completion runs the whole series again and produces a fresh result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | One-cycle start pulse |
| sample_in | input | 16 | Converter sample, signed two's complement |
| sample_valid | input | 1 | Qualifies `sample_in` |
| result_flags | output | 5 | One pass bit per check, bit n = check n |
| result_detail | output | 8 | Failure code of the first failing check, 8'h00 if none |
| result_valid | output | 1 | High once all five checks have finished |

## Verification
The embedded assertions check the following on every cycle:
- `result_valid` stays low whenever the sequencer is in a check state.
- At most one check engine is started at a time.
- A trigger arriving mid-run never sends the sequencer back to check 0.
- Finished results hold steady.
- An all-pass result carries detail 8'h00.
- The integrator holds its value across the zero-input cycles.
- The tracked minimum never exceeds the tracked maximum when check 4 evaluates.

Only the bench scenarios can show the end-to-end outcomes. These are the pass and fail verdicts for varied, stuck-low, stuck-high and boundary-spread sample streams, the clearing of stale results on a re-trigger, and the fact that a mid-run trigger leaves the run length unchanged.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int NUM_CHECKS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK0,
        ST_CHK1,
        ST_CHK2,
        ST_CHK3,
        ST_CHK4,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] CODE_NONE  = 8'h00;
    localparam logic [7:0] CODE_WALK  = 8'hE0;
    localparam logic [7:0] CODE_INTEG = 8'hC1;
    localparam logic [7:0] CODE_BFLY  = 8'hF2;
    localparam logic [7:0] CODE_COUNT = 8'hE3;
    localparam logic [7:0] CODE_RANGE = 8'hAD;

    function automatic logic [7:0] fail_code(input logic [2:0] idx);
        logic [7:0] c;
        unique case (idx)
            3'd0:    c = CODE_WALK;
            3'd1:    c = CODE_INTEG;
            3'd2:    c = CODE_BFLY;
            3'd3:    c = CODE_COUNT;
            default: c = CODE_RANGE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bist_placeholder_chk.sv
module bist_placeholder_chk #(
    parameter int MODE  = 0,   // 0: walking one, 1: opposed counters
    parameter int WIDTH = 8,
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic pass
);
    localparam int LW = $clog2(LIMIT + 1);
    localparam int SW = $clog2(WIDTH);

    generate
        if (MODE == 0) begin : g_walk
            typedef enum logic [1:0] {W_IDLE, W_SHIFT, W_EVAL} walk_e;
            walk_e            ph_q;
            logic [WIDTH-1:0] ring_q;
            logic [SW-1:0]    step_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ph_q   <= W_IDLE;
                    ring_q <= '0;
                    step_q <= '0;
                    done   <= 1'b0;
                    pass   <= 1'b0;
                end else begin
                    done <= 1'b0;
                    unique case (ph_q)
                        W_IDLE: begin
                            if (start) begin
                                ring_q <= WIDTH'(1);
                                step_q <= '0;
                                pass   <= 1'b0;
                                ph_q   <= W_SHIFT;
                            end
                        end
                        W_SHIFT: begin
                            ring_q <= {ring_q[WIDTH-2:0], 1'b0};
                            step_q <= step_q + 1'b1;
                            if (step_q == SW'(WIDTH - 2)) ph_q <= W_EVAL;
                        end
                        W_EVAL: begin
                            pass <= (ring_q == {1'b1, {(WIDTH-1){1'b0}}});
                            done <= 1'b1;
                            ph_q <= W_IDLE;
                        end
                        default: ph_q <= W_IDLE;
                    endcase
                end
            end
        end else begin : g_count
            typedef enum logic [1:0] {C_IDLE, C_RUN, C_EVAL} cnt_e;
            cnt_e          ph_q;
            logic [LW-1:0] up_q;
            logic [LW-1:0] dn_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ph_q <= C_IDLE;
                    up_q <= '0;
                    dn_q <= '0;
                    done <= 1'b0;
                    pass <= 1'b0;
                end else begin
                    done <= 1'b0;
                    unique case (ph_q)
                        C_IDLE: begin
                            if (start) begin
                                up_q <= '0;
                                dn_q <= LW'(LIMIT);
                                pass <= 1'b0;
                                ph_q <= C_RUN;
                            end
                        end
                        C_RUN: begin
                            up_q <= up_q + 1'b1;
                            dn_q <= dn_q - 1'b1;
                            if (up_q == LW'(LIMIT - 1)) ph_q <= C_EVAL;
                        end
                        C_EVAL: begin
                            pass <= (up_q == LW'(LIMIT)) && (dn_q == '0);
                            done <= 1'b1;
                            ph_q <= C_IDLE;
                        end
                        default: ph_q <= C_IDLE;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bist_integ_chk.sv
module bist_integ_chk #(
    parameter int IN_W    = 8,
    parameter int ACC_W   = 24,
    parameter int IMPULSE = 5,
    parameter int IMP_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic pass
);
    localparam int STW = $clog2(IMP_LEN);

    typedef enum logic [1:0] {I_IDLE, I_FEED, I_EVAL} integ_e;

    integ_e                   ph_q;
    logic [STW-1:0]           step_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [IN_W-1:0]   x_in;
    logic signed [ACC_W-1:0]  x_ext;

    always_comb begin
        x_in  = (step_q == '0) ? IN_W'(IMPULSE) : '0;
        x_ext = {{(ACC_W-IN_W){x_in[IN_W-1]}}, x_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= I_IDLE;
            step_q <= '0;
            acc_q  <= '0;
            done   <= 1'b0;
            pass   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph_q)
                I_IDLE: begin
                    if (start) begin
                        acc_q  <= '0;
                        step_q <= '0;
                        pass   <= 1'b0;
                        ph_q   <= I_FEED;
                    end
                end
                I_FEED: begin
                    acc_q  <= acc_q + x_ext;
                    step_q <= step_q + 1'b1;
                    if (step_q == STW'(IMP_LEN - 1)) ph_q <= I_EVAL;
                end
                I_EVAL: begin
                    pass <= (acc_q == ACC_W'(IMPULSE));
                    done <= 1'b1;
                    ph_q <= I_IDLE;
                end
                default: ph_q <= I_IDLE;
            endcase
        end
    end

    // R3: zero-valued samples after the impulse leave the accumulator unchanged
    p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == I_FEED && step_q != '0) |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/bist_bfly_chk.sv
module bist_bfly_chk #(
    parameter int DW   = 8,
    parameter int A_RE = 8,
    parameter int B_RE = 4,
    parameter int W_RE = 2,
    parameter int W_IM = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic pass
);
    localparam int PW     = 2 * DW + 2;
    localparam int EXP_PR = B_RE * W_RE;
    localparam int EXP_PI = B_RE * W_IM;
    localparam int EXP_TR = A_RE + EXP_PR;
    localparam int EXP_TI = EXP_PI;
    localparam int EXP_BR = A_RE - EXP_PR;
    localparam int EXP_BI = -EXP_PI;

    typedef enum logic [2:0] {B_IDLE, B_LOAD, B_MUL, B_ADD, B_EVAL} bfly_e;

    bfly_e                ph_q;
    logic signed [PW-1:0] ar_q, ai_q, br_q, bi_q, wr_q, wi_q;
    logic signed [PW-1:0] pr_q, pi_q;
    logic signed [PW-1:0] tr_q, ti_q, ur_q, ui_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= B_IDLE;
            ar_q <= '0; ai_q <= '0; br_q <= '0; bi_q <= '0;
            wr_q <= '0; wi_q <= '0; pr_q <= '0; pi_q <= '0;
            tr_q <= '0; ti_q <= '0; ur_q <= '0; ui_q <= '0;
            done <= 1'b0;
            pass <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph_q)
                B_IDLE: begin
                    if (start) begin
                        pass <= 1'b0;
                        ph_q <= B_LOAD;
                    end
                end
                B_LOAD: begin
                    ar_q <= PW'(A_RE);
                    ai_q <= '0;
                    br_q <= PW'(B_RE);
                    bi_q <= '0;
                    wr_q <= PW'(W_RE);
                    wi_q <= PW'(W_IM);
                    ph_q <= B_MUL;
                end
                B_MUL: begin
                    pr_q <= br_q * wr_q - bi_q * wi_q;
                    pi_q <= br_q * wi_q + bi_q * wr_q;
                    ph_q <= B_ADD;
                end
                B_ADD: begin
                    tr_q <= ar_q + pr_q;
                    ti_q <= ai_q + pi_q;
                    ur_q <= ar_q - pr_q;
                    ui_q <= ai_q - pi_q;
                    ph_q <= B_EVAL;
                end
                B_EVAL: begin
                    pass <= (tr_q == PW'(EXP_TR)) && (ti_q == PW'(EXP_TI)) &&
                            (ur_q == PW'(EXP_BR)) && (ui_q == PW'(EXP_BI));
                    done <= 1'b1;
                    ph_q <= B_IDLE;
                end
                default: ph_q <= B_IDLE;
            endcase
        end
    end

    // R4: sum and difference outputs are symmetric about A
    p_bfly_sym_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == B_EVAL) |-> ((tr_q + ur_q) == (ar_q <<< 1)));

endmodule

// File: rtl/bist_range_chk.sv
module bist_range_chk #(
    parameter int SW     = 16,
    parameter int N_SAMP = 256,
    parameter int THRESH = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] sample_in,
    input  logic          sample_valid,
    output logic          done,
    output logic          pass
);
    localparam int CW = $clog2(N_SAMP + 1);
    localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};
    localparam logic signed [SW:0]   THR   = (SW+1)'(THRESH);

    typedef enum logic [1:0] {R_IDLE, R_CAPT, R_EVAL} range_e;

    range_e               ph_q;
    logic [CW-1:0]        cnt_q;
    logic signed [SW-1:0] mn_q, mx_q, smp;
    logic signed [SW:0]   span;

    always_comb begin
        smp  = $signed(sample_in);
        span = {mx_q[SW-1], mx_q} - {mn_q[SW-1], mn_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= R_IDLE;
            cnt_q <= '0;
            mn_q  <= S_MAX;
            mx_q  <= S_MIN;
            done  <= 1'b0;
            pass  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph_q)
                R_IDLE: begin
                    if (start) begin
                        cnt_q <= '0;
                        mn_q  <= S_MAX;
                        mx_q  <= S_MIN;
                        pass  <= 1'b0;
                        ph_q  <= R_CAPT;
                    end
                end
                R_CAPT: begin
                    if (sample_valid) begin
                        if (smp < mn_q) mn_q <= smp;
                        if (smp > mx_q) mx_q <= smp;
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(N_SAMP - 1)) ph_q <= R_EVAL;
                    end
                end
                R_EVAL: begin
                    pass <= (span > THR);
                    done <= 1'b1;
                    ph_q <= R_IDLE;
                end
                default: ph_q <= R_IDLE;
            endcase
        end
    end

    // R5: after a full capture the tracked minimum never exceeds the maximum
    p_min_le_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == R_EVAL) |-> (mn_q <= mx_q));

endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
    import bist_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int CAPTURE_N  = 256,
    parameter int SPAN_MIN   = 10,
    parameter int WALK_W     = 8,
    parameter int COUNT_LIM  = 16,
    parameter int ACC_W      = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trigger,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                sample_valid,
    output logic [4:0]          result_flags,
    output logic [7:0]          result_detail,
    output logic                result_valid
);
    seq_state_e             state_q, state_d;
    logic [NUM_CHECKS-1:0]  start_v, done_v, pass_v;
    logic [2:0]             cur_idx;
    logic                   busy;
    logic                   launched_q;
    logic                   fail_seen_q;
    logic                   cur_done, cur_pass;

    // current check index and busy indication
    always_comb begin
        busy    = 1'b1;
        cur_idx = 3'd0;
        unique case (state_q)
            ST_CHK0: cur_idx = 3'd0;
            ST_CHK1: cur_idx = 3'd1;
            ST_CHK2: cur_idx = 3'd2;
            ST_CHK3: cur_idx = 3'd3;
            ST_CHK4: cur_idx = 3'd4;
            default: busy = 1'b0;
        endcase
        cur_done = busy && done_v[cur_idx];
        cur_pass = pass_v[cur_idx];
    end

    generate
        for (genvar i = 0; i < NUM_CHECKS; i++) begin : g_start
            assign start_v[i] = busy && !launched_q && (cur_idx == 3'(i));
        end
    endgenerate

    // check engines
    bist_placeholder_chk #(.MODE(0), .WIDTH(WALK_W), .LIMIT(COUNT_LIM)) u_chk0 (
        .clk(clk), .rst_n(rst_n), .start(start_v[0]), .done(done_v[0]), .pass(pass_v[0]));

    bist_integ_chk #(.IN_W(8), .ACC_W(ACC_W), .IMPULSE(5), .IMP_LEN(7)) u_chk1 (
        .clk(clk), .rst_n(rst_n), .start(start_v[1]), .done(done_v[1]), .pass(pass_v[1]));

    bist_bfly_chk #(.DW(8), .A_RE(8), .B_RE(4), .W_RE(2), .W_IM(3)) u_chk2 (
        .clk(clk), .rst_n(rst_n), .start(start_v[2]), .done(done_v[2]), .pass(pass_v[2]));

    bist_placeholder_chk #(.MODE(1), .WIDTH(WALK_W), .LIMIT(COUNT_LIM)) u_chk3 (
        .clk(clk), .rst_n(rst_n), .start(start_v[3]), .done(done_v[3]), .pass(pass_v[3]));

    bist_range_chk #(.SW(SAMPLE_W), .N_SAMP(CAPTURE_N), .THRESH(SPAN_MIN)) u_chk4 (
        .clk(clk), .rst_n(rst_n), .start(start_v[4]), .sample_in(sample_in),
        .sample_valid(sample_valid), .done(done_v[4]), .pass(pass_v[4]));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (trigger)   state_d = ST_CHK0;
            ST_CHK0:          if (done_v[0]) state_d = ST_CHK1;
            ST_CHK1:          if (done_v[1]) state_d = ST_CHK2;
            ST_CHK2:          if (done_v[2]) state_d = ST_CHK3;
            ST_CHK3:          if (done_v[3]) state_d = ST_CHK4;
            ST_CHK4:          if (done_v[4]) state_d = ST_DONE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_flags  <= '0;
            result_detail <= CODE_NONE;
            result_valid  <= 1'b0;
            launched_q    <= 1'b0;
            fail_seen_q   <= 1'b0;
        end else if (!busy) begin
            if (trigger) begin
                result_flags  <= '0;
                result_detail <= CODE_NONE;
                result_valid  <= 1'b0;
                launched_q    <= 1'b0;
                fail_seen_q   <= 1'b0;
            end
        end else begin
            if (!launched_q) launched_q <= 1'b1;
            if (cur_done) begin
                result_flags[cur_idx] <= cur_pass;
                if (!cur_pass && !fail_seen_q) begin
                    result_detail <= fail_code(cur_idx);
                    fail_seen_q   <= 1'b1;
                end
                launched_q <= 1'b0;
                if (state_q == ST_CHK4) result_valid <= 1'b1;
            end
        end
    end

    // R8: no valid result while checks are still running
    p_valid_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !result_valid);

    // R8: finished results hold until a new trigger
    p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !trigger) |=>
        (result_valid && $stable(result_flags) && $stable(result_detail)));

    // R7: an all-pass result carries the no-failure code
    p_detail_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && result_flags == 5'b11111) |-> (result_detail == CODE_NONE));

    // R2: at most one engine is started at once
    p_one_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_v));

    // R9: a mid-run trigger never sends the sequencer back to check 0
    p_ignore_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_CHK0 && trigger) |=> (state_q != ST_CHK0));

endmodule

// File: tb/bist_sequencer_tb_top.sv
module bist_sequencer_tb_top;

    localparam int P_RAMP  = 0;
    localparam int P_CONST = 1;
    localparam int P_ALT   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trigger = 1'b0;
    logic [15:0] sample_in = '0;
    logic        sample_valid = 1'b0;
    logic [4:0]  result_flags;
    logic [7:0]  result_detail;
    logic        result_valid;

    int checks = 0;
    int failures = 0;

    int          pat_mode = P_RAMP;
    logic [15:0] val_a = '0;
    logic [15:0] val_b = '0;
    logic [15:0] ramp_q = '0;
    logic        alt_q = 1'b0;

    logic [12:0] exp_q[$];
    string       tag_q[$];
    logic        valid_prev = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bist_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .trigger(trigger),
        .sample_in(sample_in), .sample_valid(sample_valid),
        .result_flags(result_flags), .result_detail(result_detail),
        .result_valid(result_valid));

    // sample source, driven away from the active edge
    always @(negedge clk) begin
        ramp_q <= ramp_q + 16'd1;
        alt_q  <= ~alt_q;
        sample_valid <= rst_n;
        unique case (pat_mode)
            P_CONST: sample_in <= val_a;
            P_ALT:   sample_in <= alt_q ? val_a : val_b;
            default: sample_in <= ramp_q;
        endcase
    end

    task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    // monitor: pop expected result when a run completes
    always @(negedge clk) begin
        if (rst_n && result_valid && !valid_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", {19'd0, result_flags, result_detail}, 32'd0);
            end else begin
                logic [12:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({result_flags, result_detail} == e, t,
                      {19'd0, result_flags, result_detail}, {19'd0, e});
            end
        end
        valid_prev = result_valid;
    end

    // driver: queue the expectation, pulse trigger, wait for completion
    task automatic run_case(input int pm, input logic [15:0] va, input logic [15:0] vb,
                            input logic [4:0] ef, input logic [7:0] ed, input string tag,
                            input bit mid_trig, input bit chk_clear, output int len);
        pat_mode = pm;
        val_a = va;
        val_b = vb;
        exp_q.push_back({ef, ed});
        tag_q.push_back(tag);
        @(negedge clk) trigger = 1'b1;
        @(negedge clk) trigger = 1'b0;
        len = 1;
        if (chk_clear) begin
            check(result_flags == 5'b0, "R8 flags cleared on trigger", {27'd0, result_flags}, 32'd0);
            check(result_detail == 8'h00, "R8 detail cleared on trigger", {24'd0, result_detail}, 32'd0);
            check(result_valid == 1'b0, "R8 valid cleared on trigger", {31'd0, result_valid}, 32'd0);
        end
        while (!result_valid && len < 20000) begin
            @(negedge clk);
            len++;
            trigger = (mid_trig && len == 20);
        end
        trigger = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int len0;
        int len1;
        int lx;
        logic [4:0] f_save;
        logic [7:0] d_save;
        repeat (3) @(negedge clk);
        check(result_valid == 1'b0, "R1 reset valid", {31'd0, result_valid}, 32'd0);
        check(result_flags == 5'b0, "R1 reset flags", {27'd0, result_flags}, 32'd0);
        check(result_detail == 8'h00, "R1 reset detail", {24'd0, result_detail}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3 R4 R7: varied samples, every check passes
        run_case(P_RAMP, 16'd0, 16'd0, 5'b11111, 8'h00, "R2 R3 R4 R7 ramp all pass", 1'b0, 1'b0, len0);

        // R5: stuck at zero
        run_case(P_CONST, 16'h0000, 16'h0000, 5'b01111, 8'hAD, "R5 stuck-at-zero", 1'b0, 1'b0, lx);

        // R8 R10: re-trigger clears stale results and reruns
        run_case(P_RAMP, 16'd0, 16'd0, 5'b11111, 8'h00, "R10 rerun after fail", 1'b0, 1'b1, lx);

        // R5: stuck at positive full scale
        run_case(P_CONST, 16'h7FFF, 16'h7FFF, 5'b01111, 8'hAD, "R5 stuck-at-max", 1'b0, 1'b0, lx);

        // R8: results hold after completion
        f_save = result_flags;
        d_save = result_detail;
        repeat (30) @(negedge clk);
        check(result_valid && result_flags == f_save && result_detail == d_save,
              "R8 results stable", {19'd0, result_flags, result_detail}, {19'd0, f_save, d_save});

        // R6: spread of exactly the threshold fails, one more passes
        run_case(P_ALT, 16'hFFFB, 16'h0005, 5'b01111, 8'hAD, "R6 span 10 fails", 1'b0, 1'b0, lx);
        run_case(P_ALT, 16'hFFFA, 16'h0005, 5'b11111, 8'h00, "R6 span 11 passes", 1'b0, 1'b0, lx);

        // R9: mid-run trigger ignored, run length unchanged
        run_case(P_RAMP, 16'd0, 16'd0, 5'b11111, 8'h00, "R9 mid-run trigger result", 1'b1, 1'b0, len1);
        check(len1 == len0, "R9 run length with mid-run trigger", len1, len0);

        // R10: back-to-back rerun
        run_case(P_CONST, 16'h8000, 16'h8000, 5'b01111, 8'hAD, "R10 rerun stuck-at-min", 1'b0, 1'b1, lx);
        run_case(P_RAMP, 16'd0, 16'd0, 5'b11111, 8'h00, "R10 rerun recovers", 1'b0, 1'b0, lx);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected results seen", exp_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule